// File: doc/BRIEF.md
# Tamper Event Aggregator with Keyed Controls

This block gathers up to 32 single-cycle security event pulses (pin tamper, clock monitor, supply glitch, brown-out, watchdog and the like) into sticky status flags. A per-event enable mask selects which flags count. Three trigger enable bits then route the masked result to three separate outputs: one blocks flash access, one wipes the key store and one wakes the system. Software clears a flag by writing 1 to its bit position.

Sensitive settings sit behind magic-value writes. These settings are the core reset, the two clock detector enables and six tamper I/O routing bits. Each one changes only when the whole written word equals a specific key, so a stray plain write cannot flip them. An 8-bit oscillator field turns the internal high-speed oscillator off only when it holds one exact pattern. A simple register bus gives single-cycle writes and combinational reads.

Top module: `tamper_event_hub`

## Requirements
- R1: After reset every register reads 0, except the power-ready bit of the control word. Core reset, both detector enables, routing, all flags and all three triggers are low, and `hosc_en` is high.
- R2: In the control word (address 0), bit 0 is the core reset state. It sets only on a full-word write of 0x55AA and clears only on 0x5500. Any other value written there leaves it unchanged.
- R3: In the function word (address 1), bit 0 is the low-speed clock detector enable: 0x44 sets it and 0x40 clears it. Bit 1 is the high-speed detector enable: 0x34 sets it and 0x30 clears it. Only the full-word values count.
- R4: Routing bits 0..5 sit at bits 8..13 of the function word. The value 0x94, 0xA4, 0xB4, 0xC4, 0xD4 or 0xE4 sets routing bit 0..5 respectively. The same values with low nibble 0 clear that bit. No other bit changes.
- R5: A write to the control or function word whose value matches no key leaves every field of that word unchanged.
- R6: The oscillator field (address 5, bits 7:0) is a plain read-write field. `hosc_en` is low only while the field holds 0x5A.
- R7: An event pulse on `evt_pulse[i]` sets status bit i (address 4) at the next clock edge. The bit then stays set with no further pulse.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it as it was.
- R9: If an event pulse and a write-1 clear of the same flag land in the same cycle, the flag stays set.
- R10: The event enable mask is at address 3. Trigger enables are at address 2: bit 0 for flash block, bit 1 for key wipe and bit 2 for wake. Each trigger output equals its enable bit AND the OR of (status AND mask) over all events, so it stays high until the contributing flags are cleared or masked.
- R11: Bit 31 of the control word always reflects the `pwr_ready` input. Writes cannot change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_pulse | input | 32 | Single-cycle event pulses |
| pwr_ready | input | 1 | Tamper regulator power good |
| core_rst | output | 1 | Core reset request |
| lxt_det_en | output | 1 | Low-speed clock detector enable |
| hxt_det_en | output | 1 | High-speed clock detector enable |
| io_route | output | 6 | Tamper I/O routing bits |
| hosc_en | output | 1 | Internal high-speed oscillator enable |
| flash_block | output | 1 | Flash-protect trigger |
| key_wipe | output | 1 | Key-store wipe trigger |
| wake | output | 1 | Wakeup trigger |

## Verification
The bench targets near-miss keys: a correct key with extra upper bits, an unlisted low nibble, and an arbitrary value. A decoder that compared only part of the word, or that wrote raw data into the register, would let these corrupt the enables or routing. It also drives a clear and an event on the same flag in the same edge. A design that lets the clear win would drop a tamper record. Finally it masks a still-set flag and checks each trigger separately. A design that fanned triggers out from raw status, or shared one gate among all three, would wipe keys when only a wake was asked for.

// File: rtl/tamp_pkg.sv
package tamp_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int N_IO     = 6;
  localparam int N_TRIG   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FUNC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_OSC   = 3'd5;

  localparam logic [DATA_W-1:0] K_RST_ON   = 32'h0000_55AA;
  localparam logic [DATA_W-1:0] K_RST_OFF  = 32'h0000_5500;
  localparam logic [DATA_W-1:0] K_LXT_ON   = 32'h0000_0044;
  localparam logic [DATA_W-1:0] K_LXT_OFF  = 32'h0000_0040;
  localparam logic [DATA_W-1:0] K_HXT_ON   = 32'h0000_0034;
  localparam logic [DATA_W-1:0] K_HXT_OFF  = 32'h0000_0030;
  localparam logic [7:0]        OSC_OFF_PAT = 8'h5A;
  localparam logic [3:0]        ROUTE_HI_BASE = 4'h9;

  localparam int RPOS_LXT   = 0;
  localparam int RPOS_HXT   = 1;
  localparam int RPOS_ROUTE = 8;
  localparam int RPOS_PWR   = 31;

  typedef enum logic [1:0] {KEY_NONE, KEY_SET, KEY_CLR} key_act_e;

  // Routing key: upper bytes zero, high nibble 9..E picks the I/O,
  // low nibble 4 sets and 0 clears.
  function automatic logic route_key_hit(input logic [DATA_W-1:0] w);
    logic [3:0] hi;
    hi = w[7:4];
    return (w[DATA_W-1:8] == '0) && (w[3:0] == 4'h4 || w[3:0] == 4'h0) &&
           (hi >= ROUTE_HI_BASE) && (hi < ROUTE_HI_BASE + 4'(N_IO));
  endfunction

  function automatic logic [2:0] route_key_idx(input logic [DATA_W-1:0] w);
    return 3'(w[7:4] - ROUTE_HI_BASE);
  endfunction

  function automatic logic route_key_val(input logic [DATA_W-1:0] w);
    return w[2];
  endfunction

  function automatic key_act_e pair_key(input logic [DATA_W-1:0] w,
                                        input logic [DATA_W-1:0] k_on,
                                        input logic [DATA_W-1:0] k_off);
    if (w == k_on)  return KEY_SET;
    if (w == k_off) return KEY_CLR;
    return KEY_NONE;
  endfunction
endpackage

// File: rtl/tamp_keyed_ctrl.sv
module tamp_keyed_ctrl
  import tamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              func_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              core_rst_q,
  output logic              lxt_q,
  output logic              hxt_q,
  output logic [N_IO-1:0]   route_q
);
  key_act_e act_rst, act_lxt, act_hxt;
  logic     route_hit;
  logic [2:0] route_idx;
  logic     func_key_any;

  assign act_rst   = pair_key(wdata, K_RST_ON, K_RST_OFF);
  assign act_lxt   = pair_key(wdata, K_LXT_ON, K_LXT_OFF);
  assign act_hxt   = pair_key(wdata, K_HXT_ON, K_HXT_OFF);
  assign route_hit = route_key_hit(wdata);
  assign route_idx = route_key_idx(wdata);
  assign func_key_any = (act_lxt != KEY_NONE) || (act_hxt != KEY_NONE) || route_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_rst_q <= 1'b0;
    else if (ctrl_wr && act_rst != KEY_NONE) core_rst_q <= (act_rst == KEY_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lxt_q <= 1'b0;
    else if (func_wr && act_lxt != KEY_NONE) lxt_q <= (act_lxt == KEY_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hxt_q <= 1'b0;
    else if (func_wr && act_hxt != KEY_NONE) hxt_q <= (act_hxt == KEY_SET);
  end

  for (genvar g = 0; g < N_IO; g++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[g] <= 1'b0;
      else if (func_wr && route_hit && route_idx == 3'(g))
        route_q[g] <= route_key_val(wdata);
    end
  end

  AST_CORE_RST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata != K_RST_ON && wdata != K_RST_OFF) |=> $stable(core_rst_q)); // R2

  AST_FUNC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (func_wr && !func_key_any) |=> $stable({lxt_q, hxt_q, route_q})); // R5

  AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (func_wr && route_hit) |=> ($countones(route_q ^ $past(route_q)) <= 1)); // R4

  AST_RST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata == K_RST_ON) |=> core_rst_q); // R2
endmodule

// File: rtl/tamp_flags.sv
module tamp_flags #(
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] clr_mask,
  output logic [NUM_EVT-1:0] status_q
);
  logic [NUM_EVT-1:0] status_d;

  always_comb begin
    status_d = (status_q & ~clr_mask) | evt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_in) & ~status_q) == '0)); // R9

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr_mask) & ~$past(evt_in)) & status_q) == '0)); // R8
endmodule

// File: rtl/tamp_trig_fanout.sv
module tamp_trig_fanout
  import tamp_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] status,
  input  logic [NUM_EVT-1:0] evt_mask,
  input  logic [N_TRIG-1:0]  trig_en,
  output logic [N_TRIG-1:0]  trig_out
);
  logic armed;

  assign armed = |(status & evt_mask);

  for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
    assign trig_out[t] = armed & trig_en[t];
  end

  AST_TRIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & evt_mask) == '0) |-> (trig_out == '0)); // R10

  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_out & ~trig_en) == '0)); // R10
endmodule

// File: rtl/tamper_event_hub.sv
module tamper_event_hub
  import tamp_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               pwr_ready,
  output logic               core_rst,
  output logic               lxt_det_en,
  output logic               hxt_det_en,
  output logic [N_IO-1:0]    io_route,
  output logic               hosc_en,
  output logic               flash_block,
  output logic               key_wipe,
  output logic               wake
);
  logic               wr_ctrl, wr_func, wr_trig, wr_mask, wr_stat, wr_osc;
  logic [N_TRIG-1:0]  trig_en_q;
  logic [NUM_EVT-1:0] evt_mask_q;
  logic [7:0]         osc_field_q;
  logic [NUM_EVT-1:0] status;
  logic [NUM_EVT-1:0] clr_mask;
  logic [N_TRIG-1:0]  trig_out;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_func = bus_wr && bus_addr == A_FUNC;
  assign wr_trig = bus_wr && bus_addr == A_TRIG;
  assign wr_mask = bus_wr && bus_addr == A_MASK;
  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_osc  = bus_wr && bus_addr == A_OSC;
  assign clr_mask = wr_stat ? bus_wdata[NUM_EVT-1:0] : '0;

  tamp_keyed_ctrl u_keys (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (wr_ctrl),
    .func_wr    (wr_func),
    .wdata      (bus_wdata),
    .core_rst_q (core_rst),
    .lxt_q      (lxt_det_en),
    .hxt_q      (hxt_det_en),
    .route_q    (io_route)
  );

  tamp_flags #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_pulse),
    .clr_mask (clr_mask),
    .status_q (status)
  );

  tamp_trig_fanout #(.NUM_EVT(NUM_EVT)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status),
    .evt_mask (evt_mask_q),
    .trig_en  (trig_en_q),
    .trig_out (trig_out)
  );

  assign flash_block = trig_out[0];
  assign key_wipe    = trig_out[1];
  assign wake        = trig_out[2];
  assign hosc_en     = (osc_field_q != OSC_OFF_PAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_en_q   <= '0;
      evt_mask_q  <= '0;
      osc_field_q <= '0;
    end else begin
      if (wr_trig) trig_en_q   <= bus_wdata[N_TRIG-1:0];
      if (wr_mask) evt_mask_q  <= bus_wdata[NUM_EVT-1:0];
      if (wr_osc)  osc_field_q <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]        = core_rst;
        bus_rdata[RPOS_PWR] = pwr_ready;
      end
      A_FUNC: begin
        bus_rdata[RPOS_LXT] = lxt_det_en;
        bus_rdata[RPOS_HXT] = hxt_det_en;
        bus_rdata[RPOS_ROUTE +: N_IO] = io_route;
      end
      A_TRIG: bus_rdata[N_TRIG-1:0]  = trig_en_q;
      A_MASK: bus_rdata[NUM_EVT-1:0] = evt_mask_q;
      A_STAT: bus_rdata[NUM_EVT-1:0] = status;
      A_OSC:  bus_rdata[7:0]         = osc_field_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_PWR_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[RPOS_PWR] == pwr_ready)); // R11

  AST_OSC_PAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_osc && bus_wdata[7:0] == OSC_OFF_PAT) |=> !hosc_en); // R6
endmodule

// File: tb/tamper_event_hub_tb.sv
module tamper_event_hub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {addr[2:0], wdata[31:0], expected readback[31:0]}
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'h0000_55AA, 32'h8000_0001},  // R2 set
    {3'd0, 32'h0000_1234, 32'h8000_0001},  // R5 no key
    {3'd0, 32'h0000_5500, 32'h8000_0000},  // R2 clear
    {3'd1, 32'h0000_0044, 32'h0000_0001},  // R3 lxt on
    {3'd1, 32'h0000_0034, 32'h0000_0003},  // R3 hxt on
    {3'd1, 32'h0000_0040, 32'h0000_0002},  // R3 lxt off
    {3'd1, 32'h0000_0094, 32'h0000_0102},  // R4 io0 set
    {3'd1, 32'h0000_00E4, 32'h0000_2102},  // R4 io5 set
    {3'd1, 32'h0000_01E4, 32'h0000_2102},  // R5 extra bits
    {3'd1, 32'h0000_00B4, 32'h0000_2502},  // R4 io2 set
    {3'd1, 32'h0000_0090, 32'h0000_2402},  // R4 io0 clear
    {3'd1, 32'h0000_0030, 32'h0000_2400},  // R3 hxt off
    {3'd1, 32'h0000_0045, 32'h0000_2400}   // R5 bad nibble
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_pulse = '0;
  logic        pwr_ready = 1'b1;
  logic        core_rst, lxt_det_en, hxt_det_en, hosc_en;
  logic        flash_block, key_wipe, wake;
  logic [5:0]  io_route;
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_event_hub dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .pwr_ready(pwr_ready), .core_rst(core_rst), .lxt_det_en(lxt_det_en),
    .hxt_det_en(hxt_det_en), .io_route(io_route), .hosc_en(hosc_en),
    .flash_block(flash_block), .key_wipe(key_wipe), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  // Drive at negedge, capture at posedge, release at next negedge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [31:0] ev);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_pulse = ev;
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = '0;
    #1;
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
    #1;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    rd_chk("R1 ctrl", 3'd0, 32'h8000_0000);
    rd_chk("R1 func", 3'd1, 32'h0);
    rd_chk("R1 stat", 3'd4, 32'h0);
    chk("R1 outputs", {25'd0, core_rst, lxt_det_en, hxt_det_en, hosc_en,
                        flash_block, key_wipe, wake}, 32'h0000_0008);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32], '0);
      rd_chk($sformatf("R2/R3/R4/R5 vec%0d", i), VEC[i][66:64], VEC[i][31:0]);
    end
    chk("R4 io_route pins", {26'd0, io_route}, 32'h0000_0024);

    // R11 power-ready is read-only
    wr(3'd0, 32'hFFFF_FFFF, '0);
    rd_chk("R11 write ignored", 3'd0, 32'h8000_0000);
    pwr_ready = 1'b0;
    rd_chk("R11 follows input", 3'd0, 32'h0);

    // R6 oscillator field
    wr(3'd5, 32'h0000_005A, '0);
    chk("R6 osc off", {31'd0, hosc_en}, 32'h0);
    wr(3'd5, 32'h0000_005B, '0);
    chk("R6 osc on", {31'd0, hosc_en}, 32'h1);

    // R7 sticky set
    pulse(32'h0000_0008);
    @(negedge clk); #1;
    rd_chk("R7 flag sticky", 3'd4, 32'h0000_0008);
    chk("R10 no trig enable", {29'd0, flash_block, key_wipe, wake}, 32'h0);
    wr(3'd3, 32'h0000_0008, '0);
    wr(3'd2, 32'h0000_0001, '0);
    chk("R10 flash only", {29'd0, flash_block, key_wipe, wake}, 32'h4);
    wr(3'd3, 32'h0000_0000, '0);
    chk("R10 masked", {29'd0, flash_block, key_wipe, wake}, 32'h0);

    // R8 write 0 has no effect
    wr(3'd4, 32'h0000_0000, '0);
    rd_chk("R8 write zero", 3'd4, 32'h0000_0008);
    // R9 set beats clear
    wr(3'd4, 32'h0000_0008, 32'h0000_0008);
    rd_chk("R9 set wins", 3'd4, 32'h0000_0008);
    // R8 clear
    wr(3'd4, 32'h0000_0008, '0);
    rd_chk("R8 w1c", 3'd4, 32'h0);

    // R10 wipe + wake from another event
    wr(3'd3, 32'h0000_0020, '0);
    wr(3'd2, 32'h0000_0006, '0);
    chk("R10 idle before event", {29'd0, flash_block, key_wipe, wake}, 32'h0);
    pulse(32'h8000_0020);
    chk("R10 wipe+wake", {29'd0, flash_block, key_wipe, wake}, 32'h3);
    rd_chk("R7 two flags", 3'd4, 32'h8000_0020);
    wr(3'd4, 32'h0000_0020, '0);
    chk("R10 released", {29'd0, flash_block, key_wipe, wake}, 32'h0);
    chk("R2 core_rst pin", {31'd0, core_rst}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule